// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address. It looks the address up in a two-level page table kept in memory. A request is taken only while the walker is idle. The upper ten address bits select a slot in the first-level table, which starts at a root address held in a loadable register. That slot holds the base of a second-level table, and the next ten address bits select a slot there. The second-level slot holds the frame number. The frame number is joined with the low twelve address bits, which are left unchanged, to give the physical address.

Memory is reached through a plain read port. The walker raises a request with an address for one cycle. The memory later returns one response word, after any number of cycles. Each table slot is 32 bits wide. Bits 31:12 hold a table base or a frame number, and bit 0 is the valid bit. If the valid bit of either slot is clear, the walk ends with a one-cycle fault pulse in place of a result.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req_valid`, `xlat_valid` and `xlat_fault` are 0.
- R2: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the walk finishes. `req_valid` has no effect while the walker is busy.
- R3: The first read address is root + 4 × p1, where p1 = vaddr[31:22].
- R4: The second read address is {L1[31:12], 12'h000} + 4 × p2, where L1 is the first-level slot and p2 = vaddr[21:12]. Bits 11:1 of the slot are ignored.
- R5: A walk whose two slots both have bit 0 set ends with `xlat_valid` high for exactly one cycle. In that cycle `xlat_paddr` = {L2[31:12], vaddr[11:0]}, where L2 is the second-level slot.
- R6: If the first-level slot has bit 0 clear, no second read is issued. `xlat_fault` is high for one cycle and `xlat_paddr` is 0.
- R7: If the second-level slot has bit 0 clear, `xlat_fault` is high for one cycle, `xlat_paddr` is 0, and `xlat_valid` stays 0.
- R8: `base_we` loads `base_wdata` into the root register only in an idle cycle where `req_valid` is 0. A load attempted while busy, or in the same cycle as a request, is ignored.
- R9: Each table read raises `mem_req_valid` for exactly one cycle. The walker uses only the first `mem_rsp_valid` pulse that follows it. Responses that arrive while no read is outstanding are ignored.
- R10: In the cycle after a result or fault pulse, the walker is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Root register load strobe |
| base_wdata | input | 32 | New root address |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request can be taken |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | 32 | Byte address of the table slot |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table slot contents |
| xlat_valid | output | 1 | Translation result pulse |
| xlat_paddr | output | 32 | Physical address (0 unless xlat_valid) |
| xlat_fault | output | 1 | Invalid-slot fault pulse |

## Verification
Translations are run with index fields at zero, at their all-ones maximum, and at middle values with junk in the low slot bits. These cases separate the index scaling, the base masking and the offset pass-through. The stimulus covers an invalid first-level slot and an invalid second-level slot, which show apart the early abort and the late one. Root loads are tried in three conditions: idle, mid-walk, and in the same cycle as a request. Together with requests held high back-to-back, memory latencies of zero to two cycles, and stray responses in idle, these runs test the acceptance and ignore rules.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_L1   = 2'd1,
    WK_L2   = 2'd2,
    WK_DONE = 2'd3
  } walk_state_e;
endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_data,
  output logic [AW-1:0] root
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) root <= '0;
    else if (load_en) root <= load_data;
  end
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int AW     = 32,
  parameter int I1W    = 10,
  parameter int I2W    = 10,
  parameter int ESHIFT = 2
) (
  input  logic [AW-1:0]  root,
  input  logic [AW-1:0]  l2base,
  input  logic [I1W-1:0] idx1,
  input  logic [I2W-1:0] idx2,
  input  logic           use_l2,
  output logic [AW-1:0]  addr
);
  // table start plus index scaled by the slot size in bytes
  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] tbl,
                                              input logic [AW-1:0] idx);
    return tbl + (idx << ESHIFT);
  endfunction

  always_comb begin
    if (use_l2) addr = slot_addr(l2base, AW'(idx2));
    else        addr = slot_addr(root, AW'(idx1));
  end
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rsp_valid,
  input  logic        rsp_ok,
  output walk_state_e state,
  output logic        issue,
  output logic        l1_take,
  output logic        l2_take,
  output logic        l1_fault,
  output logic        l2_fault,
  output logic        fault_q
);
  logic issued_q;
  logic reading;
  logic take;

  assign reading  = (state == WK_L1) || (state == WK_L2);
  assign issue    = reading && !issued_q;
  assign take     = reading && issued_q && rsp_valid;
  assign l1_take  = take && (state == WK_L1) && rsp_ok;
  assign l1_fault = take && (state == WK_L1) && !rsp_ok;
  assign l2_take  = take && (state == WK_L2) && rsp_ok;
  assign l2_fault = take && (state == WK_L2) && !rsp_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= WK_IDLE;
      issued_q <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      unique case (state)
        WK_IDLE: begin
          if (start) begin
            state    <= WK_L1;
            issued_q <= 1'b0;
            fault_q  <= 1'b0;
          end
        end
        WK_L1: begin
          if (issue) issued_q <= 1'b1;
          if (l1_fault) begin
            fault_q <= 1'b1;
            state   <= WK_DONE;
          end else if (l1_take) begin
            issued_q <= 1'b0;
            state    <= WK_L2;
          end
        end
        WK_L2: begin
          if (issue) issued_q <= 1'b1;
          if (take) begin
            fault_q <= l2_fault;
            state   <= WK_DONE;
          end
        end
        default: state <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int IDX1_W = 10,
  parameter int IDX2_W = 10,
  parameter int ENT_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [ENT_W-1:0] base_wdata,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  output logic             mem_req_valid,
  output logic [ENT_W-1:0] mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             xlat_valid,
  output logic [ENT_W-1:0] xlat_paddr,
  output logic             xlat_fault
);
  localparam int OFF_W  = VA_W - IDX1_W - IDX2_W;
  localparam int FRM_W  = ENT_W - OFF_W;
  localparam int ESHIFT = $clog2(ENT_W / 8);

  // upper field of a slot, aligned to a table boundary
  function automatic logic [ENT_W-1:0] slot_base(input logic [ENT_W-1:0] s);
    return {s[ENT_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic logic [ENT_W-1:0] join_pa(input logic [FRM_W-1:0] frm,
                                              input logic [VA_W-1:0] va);
    return {frm, va[OFF_W-1:0]};
  endfunction

  walk_state_e       state;
  logic              walk_accept;
  logic              base_load;
  logic              l1_take, l2_take, l1_fault, l2_fault, fault_q;
  logic [ENT_W-1:0]  root;
  logic [VA_W-1:0]   vaddr_q;
  logic [ENT_W-1:0]  l2base_q;
  logic [FRM_W-1:0]  frame_q;
  logic              unused_rsp_bits;

  assign unused_rsp_bits = ^mem_rsp_data[OFF_W-1:1];

  assign req_ready   = (state == WK_IDLE);
  assign walk_accept = req_valid && req_ready;
  assign base_load   = base_we && req_ready && !req_valid;

  pt_base_reg #(.AW(ENT_W)) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (base_load),
    .load_data (base_wdata),
    .root      (root)
  );

  pt_walk_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (walk_accept),
    .rsp_valid (mem_rsp_valid),
    .rsp_ok    (mem_rsp_data[0]),
    .state     (state),
    .issue     (mem_req_valid),
    .l1_take   (l1_take),
    .l2_take   (l2_take),
    .l1_fault  (l1_fault),
    .l2_fault  (l2_fault),
    .fault_q   (fault_q)
  );

  pt_addr_gen #(
    .AW(ENT_W), .I1W(IDX1_W), .I2W(IDX2_W), .ESHIFT(ESHIFT)
  ) u_addr (
    .root   (root),
    .l2base (l2base_q),
    .idx1   (vaddr_q[VA_W-1 -: IDX1_W]),
    .idx2   (vaddr_q[OFF_W +: IDX2_W]),
    .use_l2 (state == WK_L2),
    .addr   (mem_req_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q  <= '0;
      l2base_q <= '0;
      frame_q  <= '0;
    end else begin
      if (walk_accept) vaddr_q  <= req_vaddr;
      if (l1_take)     l2base_q <= slot_base(mem_rsp_data);
      if (l2_take)     frame_q  <= mem_rsp_data[ENT_W-1:OFF_W];
    end
  end

  assign xlat_valid = (state == WK_DONE) && !fault_q;
  assign xlat_fault = (state == WK_DONE) && fault_q;
  assign xlat_paddr = xlat_valid ? join_pa(frame_q, vaddr_q) : '0;
endmodule

// File: rtl/pt_walk_chk.sv
module pt_walk_chk #(
  parameter int ENT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             xlat_valid,
  input logic             xlat_fault,
  input logic [ENT_W-1:0] xlat_paddr,
  input logic [ENT_W-1:0] root,
  input logic             walk_accept,
  input logic             l1_fault
);
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept |=> !req_ready);

  // R5
  excl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xlat_valid && xlat_fault));

  // R6
  l1_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_fault |=> (xlat_fault && !mem_req_valid));

  // R7
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_fault |-> (xlat_paddr == '0));

  // R8
  root_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(root));

  // R9
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R10
  back_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_valid || xlat_fault) |=> req_ready);
endmodule

bind pt_walker pt_walk_chk #(.ENT_W(ENT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .xlat_valid    (xlat_valid),
  .xlat_fault    (xlat_fault),
  .xlat_paddr    (xlat_paddr),
  .root          (root),
  .walk_accept   (walk_accept),
  .l1_fault      (l1_fault)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        xlat_valid;
  logic [31:0] xlat_paddr;
  logic        xlat_fault;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .xlat_valid(xlat_valid), .xlat_paddr(xlat_paddr), .xlat_fault(xlat_fault)
  );

  // ---------------- memory image ----------------
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // ---------------- memory responder ----------------
  bit pending = 0;
  int lat_cnt = 0;
  int lat_sel = 0;
  logic [31:0] pend_addr = '0;
  bit stray_req = 0;

  always @(negedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pending) begin
      if (lat_cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= rd(pend_addr);
        pending = 0;
      end else lat_cnt--;
    end else if (stray_req) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= 32'hFFFF_FFFF;
      stray_req = 0;
    end
    if (rst_n && mem_req_valid) begin
      pending   = 1;
      pend_addr = mem_req_addr;
      lat_cnt   = lat_sel % 3;
      lat_sel++;
    end
  end

  // ---------------- reference model ----------------
  // phases: 0 idle, 1 first read out, 2 first wait, 3 second read out,
  //         4 second wait, 5 finished
  int          m_phase = 0;
  logic [31:0] m_root = '0;
  logic [31:0] m_va = '0;
  logic [31:0] m_tbl2 = '0;
  logic [19:0] m_frame = '0;
  bit          m_bad = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_root = '0; m_bad = 0;
    end else begin
      case (m_phase)
        0: if (req_valid) begin
             m_va = req_vaddr; m_bad = 0; m_phase = 1;
           end else if (base_we) m_root = base_wdata;
        1: m_phase = 2;
        2: if (mem_rsp_valid) begin
             if (mem_rsp_data[0] == 1'b0) begin m_bad = 1; m_phase = 5; end
             else begin m_tbl2 = mem_rsp_data & 32'hFFFF_F000; m_phase = 3; end
           end
        3: m_phase = 4;
        4: if (mem_rsp_valid) begin
             m_bad = (mem_rsp_data[0] == 1'b0);
             m_frame = mem_rsp_data[31:12];
             m_phase = 5;
           end
        default: m_phase = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
    end
  endtask

  bit started = 0;
  always @(negedge clk) begin
    if (rst_n && started) begin
      logic [31:0] e_addr, e_pa;
      bit e_rv, e_ok, e_bad;
      e_rv  = (m_phase == 1) || (m_phase == 3);
      e_ok  = (m_phase == 5) && !m_bad;
      e_bad = (m_phase == 5) && m_bad;
      e_addr = (m_phase == 1) ? m_root + {20'd0, m_va[31:22], 2'b00}
                              : m_tbl2 + {20'd0, m_va[21:12], 2'b00};
      e_pa = e_ok ? {m_frame, m_va[11:0]} : 32'h0;
      chk(req_ready == (m_phase == 0), "R2/R10 req_ready", {31'd0, req_ready},
          {31'd0, m_phase == 0});
      chk(mem_req_valid == e_rv, "R9 mem_req_valid", {31'd0, mem_req_valid}, {31'd0, e_rv});
      if (e_rv && mem_req_valid)
        chk(mem_req_addr == e_addr, (m_phase == 1) ? "R3 first address" : "R4 second address",
            mem_req_addr, e_addr);
      chk(xlat_valid == e_ok, "R5 xlat_valid", {31'd0, xlat_valid}, {31'd0, e_ok});
      chk(xlat_fault == e_bad, "R6/R7 xlat_fault", {31'd0, xlat_fault}, {31'd0, e_bad});
      chk(xlat_paddr == e_pa, e_bad ? "R7 fault paddr" : "R5 paddr", xlat_paddr, e_pa);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_idle();
    do @(negedge clk); while (m_phase != 0);
  endtask

  task automatic walk(input logic [31:0] va);
    wait_idle();
    req_vaddr = va; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
  endtask

  function automatic logic [31:0] mkva(input int p1, input int p2, input int off);
    return {p1[9:0], p2[9:0], off[11:0]};
  endfunction

  task automatic map(input logic [31:0] root, input int p1, input int p2,
                     input logic [31:0] l1e, input logic [31:0] l2e);
    mem[root + p1 * 4] = l1e;
    mem[{l1e[31:12], 12'h000} + p2 * 4] = l2e;
  endtask

  localparam logic [31:0] ROOT_A = 32'h0010_0000;
  localparam logic [31:0] ROOT_B = 32'h0080_0000;

  initial begin
    map(ROOT_A, 0, 0, 32'h0020_0001, 32'hABCD_E001);
    map(ROOT_A, 1023, 1023, 32'h0030_0001, 32'h1234_5001);
    map(ROOT_A, 5, 7, 32'h0040_0001, 32'h0BEE_F0FF);
    map(ROOT_A, 9, 1, 32'h0050_0FFF, 32'h7777_7001);
    mem[32'h0040_0020] = 32'h0999_9000;          // p1=5,p2=8: second slot invalid
    map(ROOT_B, 5, 7, 32'h0060_0001, 32'h0CAF_E001);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    chk(req_ready === 1'b1, "R1 req_ready after reset", {31'd0, req_ready}, 32'd1);
    chk(mem_req_valid === 1'b0, "R1 mem_req_valid after reset", {31'd0, mem_req_valid}, 32'd0);
    chk(xlat_valid === 1'b0 && xlat_fault === 1'b0, "R1 outputs after reset",
        {30'd0, xlat_valid, xlat_fault}, 32'd0);
    started = 1;

    // R8: idle load of root
    base_wdata = ROOT_A; base_we = 1'b1;
    @(negedge clk);
    base_we = 1'b0;

    // R3 R4 R5: index extremes and junk low slot bits
    walk(mkva(0, 0, 0));
    walk(mkva(1023, 1023, 12'hFFF));
    walk(mkva(5, 7, 12'h123));
    walk(mkva(9, 1, 12'h0AB));
    // R6: unmapped first level; R7: invalid second level
    walk(mkva(6, 3, 12'h010));
    walk(mkva(5, 8, 12'h020));

    // R9: stray responses while idle
    stray_req = 1; repeat (3) @(negedge clk);
    walk(mkva(5, 7, 12'h456));

    // R8: switch root, same virtual address maps elsewhere
    base_wdata = ROOT_B; base_we = 1'b1;
    @(negedge clk);
    base_we = 1'b0;
    walk(mkva(5, 7, 12'h789));

    // R8: load attempted mid-walk is ignored
    wait_idle();
    req_vaddr = mkva(5, 7, 12'h001); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; base_wdata = ROOT_A; base_we = 1'b1;
    @(negedge clk);
    base_we = 1'b0;
    wait_idle();
    walk(mkva(5, 7, 12'h002));

    // R8: load in the same cycle as a request is ignored
    req_vaddr = mkva(5, 7, 12'h003); req_valid = 1'b1;
    base_wdata = ROOT_A; base_we = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; base_we = 1'b0;
    wait_idle();
    walk(mkva(5, 7, 12'h004));

    // R2 R10: request held high, back-to-back walks; busy cycles ignore it
    req_vaddr = mkva(5, 7, 12'h0EE); req_valid = 1'b1;
    repeat (30) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule